// File: doc/BRIEF.md
# Indirect-Window Interrupt Redirection Register Bank

This block holds the programmable routing state for a set of interrupt pins. Each pin owns one 64-bit redirection entry. The entry carries the vector, the delivery and destination modes, the polarity, the trigger mode, the mask and the destination. The bus cannot address the entries directly. Software first writes an index into a 32-bit index register. It then reads or writes a 32-bit data window, and the window acts on whichever register the index selects. Besides the entries, the index can select an identification register, a read-only version word and an arbitration word that mirrors the identification value.

Each entry has two status bits, remote-IRR and delivery status, that software writes never change. All entries are visible in parallel on a flat output bus for the delivery logic. When a write alters any entry field other than mask or polarity, the block pulses a per-pin strobe for one cycle. Downstream logic uses that strobe to rebuild its trigger-mode view. Every bus request gets a response one cycle later.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every entry holds 0x0001000000010000 (all pins masked), and the index and ID registers hold zero.
- R2: Only requests with size code 2'b10 (32-bit) at byte offset 0x000 (index) or 0x010 (window) have an effect. Any other offset or size leaves all state unchanged on write and returns zero on read. Every request, read or write, gets rsp_valid exactly one cycle later, with read data in that same cycle.
- R3: Writing the index offset stores all 32 bits, and reading the index offset returns the stored value.
- R4: A window write at index 0x00 keeps only bits 27:24 of the data in the ID register and clears the rest. A window read at index 0x02 returns the ID register value.
- R5: A window read at index 0x01 returns ((pins-1) << 16) | 0x11, which is 0x00170011 for 24 pins. Window writes at 0x01 and 0x02 change nothing.
- R6: Only bits 7:0 of the index are decoded. Indices 0x10 to 0x10+2*pins-1 select entry (index-0x10)/2. An even index selects entry bits 31:0 and an odd index selects bits 63:32.
- R7: Entry bits 12 (delivery status) and 14 (remote-IRR) read as zero whatever is written. A window write replaces every other bit of the selected 32-bit half and leaves the other half unchanged.
- R8: Window reads at unmapped indices (0x03 to 0x0F, and above the table) return zero, and window writes there change no register.
- R9: An entry write whose old-XOR-new value has a set bit outside bit 16 (mask) and bit 13 (polarity) raises tm_recompute[pin] for exactly the one cycle after the write. Writes that change only those bits, or change nothing, raise no strobe.
- R10: entry_flat[64*p+63 : 64*p] always equals the current value of entry p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | Access size code; 2'b10 is a 32-bit access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after each request |
| rsp_rdata | output | 32 | Read data (zero for writes and ignored reads) |
| entry_flat | output | 64*NUM_PINS | All redirection entries, pin p at bits 64p+63:64p |
| tm_recompute | output | NUM_PINS | One-cycle per-pin trigger-mode recompute strobe |

## Verification
The bench walks every pin, writes both halves with patterns that set the read-only bits, and checks each half through the window and on the flat bus. A design that decoded the half or the pin wrongly, or let the status bits latch, would show up there as a wrong value. It sweeps every unmapped index value with all-ones writes and reads, so a decoder with loose bounds would corrupt an entry or leak nonzero data. Writes that toggle only the mask or only the polarity must give no strobe, while a vector change must pulse it for a single cycle. A wrong ignore set would give a missing or extra pulse. Narrow-size and wrong-offset accesses, and indices with bits set above bit 7, check that nothing outside the two 32-bit locations and the low index byte is decoded.

// File: rtl/irq_route_pkg.sv
// Package: shared layout constants and types for the redirection register bank.
// Assumes an 8-bit decoded window index and 64-bit entries.
package irq_route_pkg;

    localparam int          ENTRY_W    = 64;
    localparam int          WORD_W     = 32;
    localparam int          IDX_W      = 8;
    localparam int          PIN_SEL_W  = 7;

    localparam logic [1:0]  SIZE_WORD  = 2'b10;
    localparam int          OFS_INDEX  = 'h00;
    localparam int          OFS_WINDOW = 'h10;

    localparam logic [IDX_W-1:0] IDX_ID   = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARB  = 8'h02;
    localparam int               IDX_TBL  = 'h10;

    localparam logic [WORD_W-1:0] ID_KEEP   = 32'h0F00_0000;
    localparam logic [WORD_W-1:0] VER_BASE  = 32'h0000_0011;
    localparam int                MAXRED_LSB = 16;

    localparam int BIT_DSTAT = 12;
    localparam int BIT_POL   = 13;
    localparam int BIT_RIRR  = 14;
    localparam int BIT_MASK  = 16;

    localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0001_0000_0001_0000;
    localparam logic [ENTRY_W-1:0] RO_BITS   = (64'd1 << BIT_DSTAT) | (64'd1 << BIT_RIRR);
    localparam logic [ENTRY_W-1:0] NO_NOTIFY = (64'd1 << BIT_MASK) | (64'd1 << BIT_POL);

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY
    } win_tgt_e;

    typedef struct packed {
        win_tgt_e               tgt;
        logic [PIN_SEL_W-1:0]   pin;
        logic                   hi;
    } win_sel_t;

endpackage

// File: rtl/irq_route_bus.sv
// Module: bus-side access qualifier. Turns one request into strobes for the
// index register and the data window. Assumes a single-cycle request with no
// back-pressure; anything other than a 32-bit access at the two offsets is dropped.
module irq_route_bus
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              idx_wr,
    output logic              idx_rd,
    output logic              win_wr,
    output logic              win_rd
);

    localparam logic [ADDR_W-1:0] A_INDEX  = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_WINDOW = ADDR_W'(OFS_WINDOW);

    logic word_ok;

    // Qualify the access: valid request of full word size.
    always_comb begin
        word_ok = req_valid && (req_size == SIZE_WORD);
        idx_wr  = word_ok &&  req_write && (req_addr == A_INDEX);
        idx_rd  = word_ok && !req_write && (req_addr == A_INDEX);
        win_wr  = word_ok &&  req_write && (req_addr == A_WINDOW);
        win_rd  = word_ok && !req_write && (req_addr == A_WINDOW);
    end

endmodule

// File: rtl/irq_route_windec.sv
// Module: window index decoder. Maps the low byte of the index register to the
// ID, version, arbitration register or to one half of one pin's entry.
// Assumes 2*NUM_PINS entries fit below index 0x100.
module irq_route_windec
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [WORD_W-1:0] index_q,
    output win_sel_t          sel
);

    localparam int TBL_END = IDX_TBL + 2 * NUM_PINS;

    logic [IDX_W-1:0] idx;
    logic [8:0]       rel;

    // Classify the low index byte and split table offsets into pin and half.
    always_comb begin
        idx     = index_q[IDX_W-1:0];
        rel     = {1'b0, idx} - 9'(IDX_TBL);
        sel.tgt = TGT_NONE;
        sel.pin = '0;
        sel.hi  = 1'b0;
        if (idx == IDX_ID) begin
            sel.tgt = TGT_ID;
        end else if (idx == IDX_VER) begin
            sel.tgt = TGT_VER;
        end else if (idx == IDX_ARB) begin
            sel.tgt = TGT_ARB;
        end else if ((32'(idx) >= IDX_TBL) && (32'(idx) < TBL_END)) begin
            sel.tgt = TGT_ENTRY;
            sel.pin = rel[PIN_SEL_W:1];
            sel.hi  = rel[0];
        end
    end

endmodule

// File: rtl/irq_route_entry.sv
// Module: one 64-bit redirection entry. Applies 32-bit half writes while
// protecting the status bits and flags changes outside mask and polarity.
// Assumes at most one write per cycle.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               recompute_q
);

    logic [ENTRY_W-1:0] half_mask;
    logic [ENTRY_W-1:0] data64;
    logic [ENTRY_W-1:0] entry_nxt;
    logic               notify;

    // Merge the written half into the entry, keeping status bits.
    always_comb begin
        half_mask = wr_hi ? {{WORD_W{1'b1}}, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
        data64    = wr_hi ? {wr_data, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, wr_data};
        entry_nxt = (entry_q & (~half_mask | RO_BITS)) | (data64 & half_mask & ~RO_BITS);
        notify    = |((entry_q ^ entry_nxt) & ~NO_NOTIFY);
    end

    // Hold the entry and raise a single-cycle change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q     <= ENTRY_RST;
            recompute_q <= 1'b0;
        end else begin
            recompute_q <= wr_en && notify;
            if (wr_en) begin
                entry_q <= entry_nxt;
            end
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
// Module: top of the indirect-window redirection register bank. Holds the index
// and ID registers, instantiates one entry per pin, muxes read data and returns
// a response one cycle after every request. Assumes NUM_PINS <= 120.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [1:0]                  req_size,
    input  logic [WORD_W-1:0]           req_wdata,
    output logic                        rsp_valid,
    output logic [WORD_W-1:0]           rsp_rdata,
    output logic [ENTRY_W*NUM_PINS-1:0] entry_flat,
    output logic [NUM_PINS-1:0]         tm_recompute
);

    localparam logic [WORD_W-1:0] VER_WORD = (WORD_W'(NUM_PINS - 1) << MAXRED_LSB) | VER_BASE;

    logic                idx_wr;
    logic                idx_rd;
    logic                win_wr;
    logic                win_rd;
    logic [WORD_W-1:0]   index_q;
    logic [WORD_W-1:0]   id_q;
    win_sel_t            sel;
    logic [ENTRY_W-1:0]  entries [NUM_PINS];
    logic [WORD_W-1:0]   win_data;
    logic [WORD_W-1:0]   rdata_nxt;

    irq_route_bus #(.ADDR_W(ADDR_W)) u_bus (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .idx_wr    (idx_wr),
        .idx_rd    (idx_rd),
        .win_wr    (win_wr),
        .win_rd    (win_rd)
    );

    irq_route_windec #(.NUM_PINS(NUM_PINS)) u_dec (
        .index_q (index_q),
        .sel     (sel)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic pin_wr;
        assign pin_wr = win_wr && (sel.tgt == TGT_ENTRY) && (sel.pin == PIN_SEL_W'(p));

        irq_route_entry u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (pin_wr),
            .wr_hi       (sel.hi),
            .wr_data     (req_wdata),
            .entry_q     (entries[p]),
            .recompute_q (tm_recompute[p])
        );

        assign entry_flat[ENTRY_W*p +: ENTRY_W] = entries[p];
    end

    // Index register: full word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (idx_wr) begin
            index_q <= req_wdata;
        end
    end

    // ID register: only the ID field is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (win_wr && (sel.tgt == TGT_ID)) begin
            id_q <= req_wdata & ID_KEEP;
        end
    end

    // Select the word the window shows for the current index.
    always_comb begin
        win_data = '0;
        case (sel.tgt)
            TGT_ID:    win_data = id_q;
            TGT_VER:   win_data = VER_WORD;
            TGT_ARB:   win_data = id_q;
            TGT_ENTRY: begin
                if (sel.hi) begin
                    win_data = entries[sel.pin[$clog2(NUM_PINS)-1:0]][ENTRY_W-1:WORD_W];
                end else begin
                    win_data = entries[sel.pin[$clog2(NUM_PINS)-1:0]][WORD_W-1:0];
                end
            end
            default:   win_data = '0;
        endcase
    end

    // Pick the response data for this request.
    always_comb begin
        rdata_nxt = '0;
        if (idx_rd) begin
            rdata_nxt = index_q;
        end else if (win_rd) begin
            rdata_nxt = win_data;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rdata_nxt;
        end
    end

endmodule

// File: rtl/irq_route_regs_chk.sv
// Module: protocol and state checker for irq_route_regs, attached by bind.
// Assumes the same parameters as the bound instance.
module irq_route_regs_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [1:0]                  req_size,
    input  logic                        rsp_valid,
    input  logic [WORD_W-1:0]           rsp_rdata,
    input  logic [ENTRY_W*NUM_PINS-1:0] entry_flat,
    input  logic [NUM_PINS-1:0]         tm_recompute
);

    logic                win_write;
    logic [NUM_PINS-1:0] ro_set;

    // Identify a qualified 32-bit window write.
    assign win_write = req_valid && req_write && (req_size == SIZE_WORD)
                       && (req_addr == ADDR_W'(OFS_WINDOW));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ro
        assign ro_set[p] = entry_flat[ENTRY_W*p + BIT_DSTAT] | entry_flat[ENTRY_W*p + BIT_RIRR];
    end

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_narrow_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_size != SIZE_WORD)) |=> (rsp_rdata == '0));

    assert_entries_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_write |=> $stable(entry_flat));

    assert_status_bits_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ro_set == '0);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tm_recompute));

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_recompute != '0) |-> $past(win_write));

endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .entry_flat   (entry_flat),
    .tm_recompute (tm_recompute)
);

// File: tb/irq_route_regs_tb.sv
// Bench: sweeps every pin and every index value against an arithmetic model.
module irq_route_regs_tb;

    localparam int NP = 24;
    localparam int AW = 12;
    localparam logic [63:0] RST_E = 64'h0001_0000_0001_0000;
    localparam logic [63:0] RO_M  = (64'd1 << 12) | (64'd1 << 14);
    localparam logic [63:0] IGN_M = (64'd1 << 16) | (64'd1 << 13);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_write;
    logic [AW-1:0]   req_addr;
    logic [1:0]      req_size;
    logic [31:0]     req_wdata;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [64*NP-1:0] entry_flat;
    logic [NP-1:0]   tm_recompute;

    int checks = 0;
    int errors = 0;

    logic [63:0] mdl [NP];
    logic [31:0] m_id;
    logic [31:0] m_index;

    always #5 clk = ~clk;

    irq_route_regs #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .entry_flat   (entry_flat),
        .tm_recompute (tm_recompute)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic [NP-1:0] stb);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        rd  = rsp_rdata;
        stb = tm_recompute;
        chk("R2 response valid", 64'(rsp_valid), 64'd1);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] idx);
        int off;
        if (idx == 8'h00 || idx == 8'h02) return m_id;
        if (idx == 8'h01) return 32'h0017_0011;
        off = int'(idx) - 'h10;
        if (off >= 0 && off < 2 * NP) begin
            return off[0] ? mdl[off / 2][63:32] : mdl[off / 2][31:0];
        end
        return 32'h0;
    endfunction

    function automatic logic [NP-1:0] model_write(input logic [7:0] idx, input logic [31:0] d);
        int off;
        logic [63:0] m, d64, old;
        logic [NP-1:0] s;
        s = '0;
        if (idx == 8'h00) m_id = d & 32'h0F00_0000;
        off = int'(idx) - 'h10;
        if (off >= 0 && off < 2 * NP) begin
            m   = off[0] ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            d64 = off[0] ? {d, 32'h0} : {32'h0, d};
            old = mdl[off / 2];
            mdl[off / 2] = (old & ~m) | (d64 & m & ~RO_M);
            if (((old ^ mdl[off / 2]) & ~IGN_M) != 0) s[off / 2] = 1'b1;
        end
        return s;
    endfunction

    task automatic set_index(input logic [31:0] v);
        logic [31:0] rd;
        logic [NP-1:0] st;
        access(1'b1, 'h000, 2'b10, v, rd, st);
        m_index = v;
    endtask

    task automatic win_wr(input string tag, input logic [31:0] d);
        logic [31:0] rd;
        logic [NP-1:0] st, exp_s;
        exp_s = model_write(m_index[7:0], d);
        access(1'b1, 'h010, 2'b10, d, rd, st);
        chk({tag, " strobe"}, 64'(st), 64'(exp_s));
    endtask

    task automatic win_rd(input string tag);
        logic [31:0] rd;
        logic [NP-1:0] st;
        access(1'b0, 'h010, 2'b10, 32'h0, rd, st);
        chk(tag, 64'(rd), 64'(model_read(m_index[7:0])));
    endtask

    task automatic chk_flat(input string tag);
        for (int p = 0; p < NP; p++) chk(tag, entry_flat[64*p +: 64], mdl[p]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [NP-1:0] st;
        for (int p = 0; p < NP; p++) mdl[p] = RST_E;
        m_id = '0;
        m_index = '0;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_size = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: reset contents on the flat bus and through the window
        chk_flat("R1 R10 reset entry");
        access(1'b0, 'h000, 2'b10, 32'h0, rd, st);
        chk("R1 index reset", 64'(rd), 64'd0);
        for (int i = 0; i < 'h10 + 2 * NP; i++) begin
            set_index(32'(i));
            win_rd("R1 R6 reset window read");
        end

        // R3: index register stores full 32 bits
        set_index(32'hDEAD_BE11);
        access(1'b0, 'h000, 2'b10, 32'h0, rd, st);
        chk("R3 index readback", 64'(rd), 64'hDEAD_BE11);

        // R4: ID keeps bits 27:24, arbitration mirrors it
        set_index(32'h0000_0000);
        win_wr("R4 ID write", 32'hFFFF_FFFF);
        win_rd("R4 ID read");
        set_index(32'h0000_0002);
        win_rd("R4 arbitration read");
        chk("R4 ID value", 64'(m_id), 64'h0F00_0000);

        // R5: version value, and version/arbitration writes ignored
        set_index(32'h0000_0001);
        access(1'b0, 'h010, 2'b10, 32'h0, rd, st);
        chk("R5 version", 64'(rd), 64'h0017_0011);
        win_wr("R5 version write", 32'h0);
        win_rd("R5 version after write");
        set_index(32'h0000_0002);
        win_wr("R5 arbitration write", 32'h0);
        win_rd("R5 arbitration after write");
        set_index(32'h0000_0000);
        win_rd("R5 ID after ignored writes");

        // R6 / R7 / R9 / R10: every pin, both halves, status bits forced in data
        for (int p = 0; p < NP; p++) begin
            set_index(32'(('h10 + 2 * p)));
            win_wr("R7 R9 low write", 32'h0000_5000 | (32'(p) * 32'h0301_0A05) ^ 32'h0002_A0C3);
            win_rd("R6 R7 low read");
            set_index(32'(('h11 + 2 * p)));
            win_wr("R9 high write", {8'(p + 1), 24'h00A5_5A});
            win_rd("R6 R7 high read");
        end
        chk_flat("R7 R10 pin sweep");

        // R6: only low 8 bits of index decoded
        set_index(32'hABCD_0112);
        win_wr("R6 high index bits write", 32'h0000_7E41);
        win_rd("R6 high index bits read");
        chk_flat("R6 R10 aliased index");

        // R9: mask-only, polarity-only, same value give no strobe; vector change strobes once
        set_index(32'h0000_0016);
        win_wr("R9 baseline", 32'h0000_0030);
        win_wr("R9 mask only", 32'h0001_0030);
        win_wr("R9 polarity only", 32'h0001_2030);
        win_wr("R9 unchanged", 32'h0001_2030);
        win_wr("R9 trigger mode change", 32'h0001_A030);
        win_wr("R9 vector change", 32'h0001_A031);
        @(negedge clk);
        chk("R9 strobe drops", 64'(tm_recompute), 64'd0);
        set_index(32'h0000_0017);
        win_wr("R9 destination change", 32'h7700_0000);

        // R8: unmapped indices read zero and write nothing
        for (int i = 3; i < 256; i++) begin
            if (i >= 'h10 && i < 'h10 + 2 * NP) continue;
            set_index(32'(i));
            win_wr("R8 unmapped write", 32'hFFFF_FFFF);
            win_rd("R8 unmapped read");
        end
        chk_flat("R8 entries after unmapped writes");
        set_index(32'h0000_0000);
        win_rd("R8 ID after unmapped writes");

        // R2: narrow sizes and other offsets are ignored
        set_index(32'h0000_0010);
        access(1'b1, 'h010, 2'b01, 32'h1234_5678, rd, st);
        chk("R2 narrow write no strobe", 64'(st), 64'd0);
        chk_flat("R2 narrow window write");
        access(1'b1, 'h004, 2'b10, 32'h0000_0020, rd, st);
        access(1'b1, 'h000, 2'b11, 32'h0000_0021, rd, st);
        access(1'b0, 'h000, 2'b10, 32'h0, rd, st);
        chk("R2 index untouched", 64'(rd), 64'(m_index));
        access(1'b0, 'h000, 2'b00, 32'h0, rd, st);
        chk("R2 narrow read zero", 64'(rd), 64'd0);
        access(1'b0, 'h020, 2'b10, 32'h0, rd, st);
        chk("R2 other offset read zero", 64'(rd), 64'd0);
        access(1'b0, 'h110, 2'b10, 32'h0, rd, st);
        chk("R2 aliased offset read zero", 64'(rd), 64'd0);
        win_rd("R2 window still live");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule